// File: doc/BRIEF.md
# Audio Sample Buffer with Codec-Driven DMA Requests

This block sits between a processor or DMA register port and a codec-side sample interface, and holds one sample buffer in each direction. Outgoing samples are written one at a time through a write port and collect in the transmit buffer. When the buffer fills, or when its fill level matches the free space the codec last reported, the whole batch goes out to the codec as a burst on a valid/ready stream. Incoming audio works in the other direction. The codec reports how many words it has waiting. Whenever the receive buffer is empty and words are pending, the block pulls a block of them over a second valid/ready stream, and reads of the data-read port then return those words one by one.

There is one DMA request line per direction, each gated by its own enable input. The receive request tracks words that are buffered or still pending at the codec. The transmit request tracks whether the buffer still has room below the codec's reported free space. Both requests follow the codec's reports rather than fixed watermarks. A configuration-change pulse stands for a rewrite of the audio format: it sends out whatever transmit data can be sent, then clears all counts. Every sample is held as a 16-bit word, whatever sample width the format uses.

Top module: `audio_sample_buf`

## Requirements
- R1: After reset both DMA requests are low, `wr_ready` is high, `tx_valid` and `rx_ready` are low, and a read returns zero.
- R2: Each accepted write appends one 16-bit sample. When the buffered count reaches DEPTH (1024 by default), or equals a nonzero reported free space, all buffered samples go out on `tx_data` in write order, one per accepted `tx_valid`/`tx_ready` transfer. While a transfer is stalled, the data stays stable.
- R3: If the reported free space is zero when the count reaches DEPTH, the buffered samples are discarded without any transmit transfer and the count returns to zero.
- R4: From the cycle after a burst starts until its last sample is accepted, `wr_ready` is low and no write is taken.
- R5: A free-space report replaces the stored free space and clips the buffered count to the reported value, dropping the newest samples. If the clipped count is nonzero, that many samples are sent. After any burst, the stored free space goes down by the number of samples sent.
- R6: `tx_drq` is high one cycle after a cycle in which `tx_dma_en` is high, no burst is in progress, and the buffered count is below the stored free space. Otherwise it is low.
- R7: While the receive buffer is empty and the pending count is nonzero, a refill runs. It takes min(pending, DEPTH) words in arrival order over the `rx_valid`/`rx_ready` stream and lowers the pending count by that amount. A report on `rx_avail_upd` overwrites the pending count.
- R8: A read (`rd_req`) gives `rd_valid` high one cycle later with the oldest unread buffered sample on `rd_data`. A read of an empty buffer, or a read during a refill, returns zero and consumes nothing.
- R9: Reading the last buffered sample starts a new refill if words remain pending. Otherwise the buffer stays empty and `rx_drq` falls.
- R10: `rx_drq` is high one cycle after a cycle in which `rx_dma_en` is high, no refill is running or starting, and pending plus buffered words is nonzero.
- R11: A `cfg_change` pulse sends out the buffered transmit samples, up to the stored free space, and then sets the free space to zero. It also clears the receive pending and buffered counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_change | input | 1 | Format rewrite pulse (R11) |
| tx_dma_en | input | 1 | Transmit DMA request enable |
| rx_dma_en | input | 1 | Receive DMA request enable |
| wr_valid | input | 1 | Data-write port strobe |
| wr_data | input | SAMPLE_W | Sample to append |
| wr_ready | output | 1 | Write port can take a sample |
| rd_req | input | 1 | Data-read port strobe |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | SAMPLE_W | Read result |
| tx_space_upd | input | 1 | Codec free-space report strobe |
| tx_space_val | input | CNT_W | Reported free space in words |
| tx_valid | output | 1 | Outgoing sample valid |
| tx_data | output | SAMPLE_W | Outgoing sample |
| tx_ready | input | 1 | Codec accepts outgoing sample |
| rx_avail_upd | input | 1 | Codec pending-words report strobe |
| rx_avail_val | input | CNT_W | Reported pending words |
| rx_valid | input | 1 | Incoming word valid |
| rx_data | input | SAMPLE_W | Incoming word |
| rx_ready | output | 1 | Block takes incoming word |
| tx_drq | output | 1 | Transmit DMA request |
| rx_drq | output | 1 | Receive DMA request |

## Verification
The bench targets the two transmit flush triggers (full buffer and count equal to free space), clipping by a shrinking free-space report, and discard when free space is zero. A design that got flushing wrong would send a burst at the wrong length, send samples out of order, or send nothing at all. A design that got clipping or discard wrong would send dropped samples, or keep a stale count, which would leave `tx_drq` low when it should be high. On the receive side, the bench reports more words than the buffer holds, so it can check that a refill stops at DEPTH and that a second refill starts once the last word is read. It also checks that reads during a refill, and reads of an empty buffer, return zero without losing data. A configuration pulse must flush the transmit data and clear the receive counts; a design that ignored it would leave a request high or return stale receive words.

// File: rtl/asb_pkg.sv
package asb_pkg;
  typedef enum logic { TX_FILL = 1'b0, TX_DRAIN = 1'b1 } tx_state_e;
  typedef enum logic { RX_IDLE = 1'b0, RX_FILL  = 1'b1 } rx_state_e;
endpackage

// File: rtl/asb_sample_ram.sv
module asb_sample_ram #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // simple dual port, registered read with enable: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/asb_tx.sv
module asb_tx
  import asb_pkg::*;
#(
  parameter int DEPTH    = 1024,
  parameter int SAMPLE_W = 16,
  parameter int CNT_W    = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_change,
  input  logic                dma_en,
  input  logic                wr_valid,
  input  logic [SAMPLE_W-1:0] wr_data,
  output logic                wr_ready,
  input  logic                space_upd,
  input  logic [CNT_W-1:0]    space_val,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_data,
  input  logic                out_ready,
  output logic                drq
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  tx_state_e        st;
  logic [CNT_W-1:0] cnt, space, len, rptr;
  logic             clr_space;
  logic             wr_fire, hit, ram_re, done;
  logic [CNT_W-1:0] cnt_inc, clip_upd, clip_cfg;

  assign wr_ready = (st == TX_FILL) && !space_upd && !cfg_change;
  assign wr_fire  = wr_valid && wr_ready;
  assign cnt_inc  = cnt + ONE;
  assign hit      = (cnt_inc == DEPTH_C) || (cnt_inc == space);
  assign clip_upd = (cnt < space_val) ? cnt : space_val;
  assign clip_cfg = (cnt < space) ? cnt : space;
  assign ram_re   = (st == TX_DRAIN) && (rptr != len) && (!out_valid || out_ready);
  assign done     = (st == TX_DRAIN) && (rptr == len) && (!out_valid || out_ready);

  asb_sample_ram #(.DEPTH(DEPTH), .WIDTH(SAMPLE_W)) u_ram (
    .clk  (clk),
    .we   (wr_fire),
    .waddr(cnt[AW-1:0]),
    .wdata(wr_data),
    .re   (ram_re),
    .raddr(rptr[AW-1:0]),
    .rdata(out_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= TX_FILL;
      cnt       <= '0;
      space     <= '0;
      len       <= '0;
      rptr      <= '0;
      clr_space <= 1'b0;
      out_valid <= 1'b0;
      drq       <= 1'b0;
    end else begin
      drq <= dma_en && (st == TX_FILL) && (cnt < space);
      if (ram_re)         out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
      case (st)
        TX_FILL: begin
          rptr <= '0;
          if (cfg_change) begin
            if (cnt != '0 && space != '0) begin
              len       <= clip_cfg;
              clr_space <= 1'b1;
              st        <= TX_DRAIN;
            end else begin
              cnt   <= '0;
              space <= '0;
            end
          end else if (space_upd) begin
            space <= space_val;
            cnt   <= clip_upd;
            if (clip_upd != '0) begin
              len       <= clip_upd;
              clr_space <= 1'b0;
              st        <= TX_DRAIN;
            end
          end else if (wr_fire) begin
            if (hit && space == '0) begin
              cnt <= '0;
            end else begin
              cnt <= cnt_inc;
              if (hit) begin
                len       <= cnt_inc;
                clr_space <= 1'b0;
                st        <= TX_DRAIN;
              end
            end
          end
        end
        TX_DRAIN: begin
          if (cfg_change) clr_space <= 1'b1;
          if (ram_re) rptr <= rptr + ONE;
          if (done) begin
            st        <= TX_FILL;
            cnt       <= '0;
            space     <= (clr_space || cfg_change) ? '0 : space - len;
            clr_space <= 1'b0;
          end
        end
        default: st <= TX_FILL;
      endcase
    end
  end
endmodule

// File: rtl/asb_rx.sv
module asb_rx
  import asb_pkg::*;
#(
  parameter int DEPTH    = 1024,
  parameter int SAMPLE_W = 16,
  parameter int CNT_W    = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_change,
  input  logic                dma_en,
  input  logic                avail_upd,
  input  logic [CNT_W-1:0]    avail_val,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_data,
  output logic                in_ready,
  input  logic                rd_req,
  output logic                rd_valid,
  output logic [SAMPLE_W-1:0] rd_data,
  output logic                drq
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  rx_state_e        st;
  logic [CNT_W-1:0] pend, cnt, len, wptr, rptr, take;
  logic             start, rd_hit, in_fire, rd_zero;
  logic [SAMPLE_W-1:0] ram_q;

  assign take     = (pend > DEPTH_C) ? DEPTH_C : pend;
  assign start    = (st == RX_IDLE) && (cnt == '0) && (pend != '0) && !cfg_change;
  assign in_ready = (st == RX_FILL) && !cfg_change;
  assign in_fire  = in_valid && in_ready;
  assign rd_hit   = rd_req && (st == RX_IDLE) && (cnt != '0);
  assign rd_data  = rd_zero ? '0 : ram_q;

  asb_sample_ram #(.DEPTH(DEPTH), .WIDTH(SAMPLE_W)) u_ram (
    .clk  (clk),
    .we   (in_fire),
    .waddr(wptr[AW-1:0]),
    .wdata(in_data),
    .re   (rd_hit),
    .raddr(rptr[AW-1:0]),
    .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= RX_IDLE;
      pend     <= '0;
      cnt      <= '0;
      len      <= '0;
      wptr     <= '0;
      rptr     <= '0;
      rd_valid <= 1'b0;
      rd_zero  <= 1'b1;
      drq      <= 1'b0;
    end else begin
      drq      <= dma_en && (st == RX_IDLE) && !start && (pend != '0 || cnt != '0);
      rd_valid <= rd_req;
      rd_zero  <= !rd_hit;
      case (st)
        RX_IDLE: begin
          if (cfg_change) begin
            pend <= '0;
            cnt  <= '0;
          end else begin
            if (start) begin
              len  <= take;
              pend <= pend - take;
              wptr <= '0;
              st   <= RX_FILL;
            end
            if (rd_hit) begin
              rptr <= rptr + ONE;
              cnt  <= cnt - ONE;
            end
            if (avail_upd) pend <= avail_val;
          end
        end
        RX_FILL: begin
          if (cfg_change) begin
            st   <= RX_IDLE;
            pend <= '0;
            cnt  <= '0;
          end else begin
            if (in_fire) begin
              wptr <= wptr + ONE;
              if (wptr + ONE == len) begin
                st   <= RX_IDLE;
                cnt  <= len;
                rptr <= '0;
              end
            end
            if (avail_upd) pend <= avail_val;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/audio_sample_buf.sv
module audio_sample_buf #(
  parameter int DEPTH    = 1024,
  parameter int SAMPLE_W = 16,
  parameter int CNT_W    = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_change,
  input  logic                tx_dma_en,
  input  logic                rx_dma_en,
  input  logic                wr_valid,
  input  logic [SAMPLE_W-1:0] wr_data,
  output logic                wr_ready,
  input  logic                rd_req,
  output logic                rd_valid,
  output logic [SAMPLE_W-1:0] rd_data,
  input  logic                tx_space_upd,
  input  logic [CNT_W-1:0]    tx_space_val,
  output logic                tx_valid,
  output logic [SAMPLE_W-1:0] tx_data,
  input  logic                tx_ready,
  input  logic                rx_avail_upd,
  input  logic [CNT_W-1:0]    rx_avail_val,
  input  logic                rx_valid,
  input  logic [SAMPLE_W-1:0] rx_data,
  output logic                rx_ready,
  output logic                tx_drq,
  output logic                rx_drq
);
  asb_tx #(.DEPTH(DEPTH), .SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .cfg_change(cfg_change),
    .dma_en    (tx_dma_en),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .wr_ready  (wr_ready),
    .space_upd (tx_space_upd),
    .space_val (tx_space_val),
    .out_valid (tx_valid),
    .out_data  (tx_data),
    .out_ready (tx_ready),
    .drq       (tx_drq)
  );

  asb_rx #(.DEPTH(DEPTH), .SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .cfg_change(cfg_change),
    .dma_en    (rx_dma_en),
    .avail_upd (rx_avail_upd),
    .avail_val (rx_avail_val),
    .in_valid  (rx_valid),
    .in_data   (rx_data),
    .in_ready  (rx_ready),
    .rd_req    (rd_req),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .drq       (rx_drq)
  );
endmodule

// File: rtl/asb_checker.sv
module asb_checker #(
  parameter int SAMPLE_W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_ready,
  input logic                tx_valid,
  input logic                tx_ready,
  input logic [SAMPLE_W-1:0] tx_data,
  input logic                tx_drq,
  input logic                tx_dma_en,
  input logic                rx_ready,
  input logic                rx_drq,
  input logic                rx_dma_en
);
  assert_no_write_in_burst_R4: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> !wr_ready);

  assert_stall_holds_data_R2: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  assert_tx_req_enabled_R6: assert property (@(posedge clk) disable iff (rst)
    tx_drq |-> $past(tx_dma_en));

  assert_tx_req_quiet_in_burst_R6: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> !tx_drq);

  assert_rx_req_enabled_R10: assert property (@(posedge clk) disable iff (rst)
    rx_drq |-> $past(rx_dma_en));

  assert_rx_req_quiet_in_refill_R7: assert property (@(posedge clk) disable iff (rst)
    rx_ready |-> !rx_drq);
endmodule

bind audio_sample_buf asb_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (.*);

// File: tb/sim_audio_sample_buf.sv
`timescale 1ns/1ps
module sim_audio_sample_buf;
  localparam int DEPTH = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_change = 1'b0, tx_dma_en = 1'b0, rx_dma_en = 1'b0;
  logic        wr_valid = 1'b0, rd_req = 1'b0;
  logic [15:0] wr_data = '0;
  logic        tx_space_upd = 1'b0, rx_avail_upd = 1'b0;
  logic [15:0] tx_space_val = '0, rx_avail_val = '0;
  logic        tx_ready = 1'b1, rx_valid = 1'b0;
  logic [15:0] rx_data = '0;
  logic        wr_ready, rd_valid, tx_valid, rx_ready, tx_drq, rx_drq;
  logic [15:0] rd_data, tx_data;

  always #2 clk = ~clk;

  audio_sample_buf u0 (
    .clk(clk), .rst(rst), .cfg_change(cfg_change), .tx_dma_en(tx_dma_en),
    .rx_dma_en(rx_dma_en), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
    .tx_space_upd(tx_space_upd), .tx_space_val(tx_space_val), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .rx_avail_upd(rx_avail_upd),
    .rx_avail_val(rx_avail_val), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .tx_drq(tx_drq), .rx_drq(rx_drq)
  );

  int nchk = 0, nfail = 0;
  bit finished = 1'b0, bp_mode = 1'b0, rx_took = 1'b0;
  int m_cnt = 0, m_space = 0;
  logic [15:0] seq = 16'h0100;
  logic [15:0] m_pend[$], tx_exp[$], rx_exp[$], rx_src[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ---------------- reference model of the transmit side ----------------
  task automatic m_drain(input int n);
    for (int i = 0; i < n; i++) tx_exp.push_back(m_pend[i]);
    m_pend.delete();
    m_space -= n;
    m_cnt = 0;
  endtask

  task automatic m_write(input logic [15:0] d);
    m_pend.push_back(d);
    m_cnt++;
    if (m_cnt == DEPTH || m_cnt == m_space) begin
      if (m_space != 0) m_drain(m_cnt);
      else begin m_pend.delete(); m_cnt = 0; end
    end
  endtask

  // ---------------- transmit monitor (scoreboard) ----------------
  always @(negedge clk) begin
    if (!rst && tx_valid && tx_ready) begin
      if (tx_exp.size() == 0) begin
        nchk++; nfail++;
        $display("FAIL R2: unexpected tx sample actual %0d expected none", tx_data);
      end else begin
        automatic logic [15:0] e = tx_exp.pop_front();
        check(tx_data == e, "R2 tx sample order", tx_data, e);
      end
    end
    tx_ready = bp_mode ? ~tx_ready : 1'b1;
  end

  // ---------------- receive source ----------------
  always @(negedge clk) begin
    if (rx_took && rx_src.size() > 0) void'(rx_src.pop_front());
    rx_valid = rx_src.size() > 0;
    rx_data  = (rx_src.size() > 0) ? rx_src[0] : 16'h0;
    rx_took  = rx_valid && rx_ready;
  end

  // ---------------- driver tasks ----------------
  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    m_write(d);
  endtask

  task automatic wr_seq(input int n);
    for (int i = 0; i < n; i++) begin wr(seq); seq++; end
  endtask

  task automatic wait_idle;
    @(negedge clk);
    while (!wr_ready || tx_exp.size() != 0 || tx_valid) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic space_rep(input int v);
    int n;
    wait_idle();
    tx_space_upd = 1'b1; tx_space_val = 16'(v);
    @(negedge clk);
    tx_space_upd = 1'b0;
    n = (m_cnt < v) ? m_cnt : v;
    m_space = v;
    if (n > 0) m_drain(n);
    else begin m_pend.delete(); m_cnt = 0; end
  endtask

  task automatic cfg_pulse;
    wait_idle();
    cfg_change = 1'b1;
    @(negedge clk);
    cfg_change = 1'b0;
    if (m_cnt != 0 && m_space != 0) m_drain((m_cnt < m_space) ? m_cnt : m_space);
    m_space = 0; m_cnt = 0; m_pend.delete();
  endtask

  task automatic rx_rep(input int v);
    @(negedge clk);
    rx_avail_upd = 1'b1; rx_avail_val = 16'(v);
    @(negedge clk);
    rx_avail_upd = 1'b0;
  endtask

  task automatic push_src(input int n, input bit expect_it);
    for (int i = 0; i < n; i++) begin
      rx_src.push_back(seq);
      if (expect_it) rx_exp.push_back(seq);
      seq++;
    end
  endtask

  task automatic rd_check(input logic [15:0] exp, input string tag);
    @(negedge clk);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    check(rd_valid && rd_data == exp, tag, rd_data, exp);
  endtask

  task automatic rd_next(input string tag);
    rd_check(rx_exp.pop_front(), tag);
  endtask

  task automatic wait_src(input int left);
    while (rx_src.size() > left) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R1 reset state
    check(wr_ready == 1'b1, "R1 wr_ready after reset", wr_ready, 1);
    check(tx_valid == 1'b0, "R1 tx_valid after reset", tx_valid, 0);
    check(rx_ready == 1'b0, "R1 rx_ready after reset", rx_ready, 0);
    check(tx_drq == 1'b0 && rx_drq == 1'b0, "R1 requests after reset", tx_drq | rx_drq, 0);
    rd_check(16'h0, "R1 R8 empty read after reset");

    // R6 transmit request follows free space and enable
    tx_dma_en = 1'b1;
    space_rep(4);
    repeat (3) @(negedge clk);
    check(tx_drq == 1'b1, "R6 tx_drq with room", tx_drq, 1);
    tx_dma_en = 1'b0;
    repeat (3) @(negedge clk);
    check(tx_drq == 1'b0, "R6 tx_drq gated by enable", tx_drq, 0);
    tx_dma_en = 1'b1;

    // R2 flush at free-space count, R4 writes held off
    wr_seq(4);
    check(wr_ready == 1'b0, "R4 wr_ready low during burst", wr_ready, 0);
    wait_idle();
    check(tx_drq == 1'b0, "R5 free space consumed by burst", tx_drq, 0);

    // R2 with backpressure
    bp_mode = 1'b1;
    space_rep(6);
    wr_seq(6);
    wait_idle();
    bp_mode = 1'b0;

    // R5 clipping by a smaller report
    space_rep(100);
    wr_seq(3);
    space_rep(2);
    wait_idle();
    check(tx_drq == 1'b0, "R5 space zero after clipped burst", tx_drq, 0);
    space_rep(5);
    repeat (3) @(negedge clk);
    check(tx_drq == 1'b1, "R5 clipped sample dropped", tx_drq, 1);

    // R3 discard at full buffer with zero free space
    space_rep(0);
    wr_seq(DEPTH);
    space_rep(5);
    repeat (3) @(negedge clk);
    check(tx_drq == 1'b1, "R3 count cleared after discard", tx_drq, 1);

    // R2 flush on full buffer, R5 free space reduced afterwards
    space_rep(2000);
    wr_seq(DEPTH);
    wait_idle();
    check(tx_drq == 1'b1, "R5 remaining space after full burst", tx_drq, 1);
    wr_seq(2000 - DEPTH);
    wait_idle();
    check(tx_drq == 1'b0, "R5 flush at reduced space", tx_drq, 0);

    // R11 configuration change flushes transmit data
    space_rep(10);
    wr_seq(3);
    cfg_pulse();
    wait_idle();
    check(tx_drq == 1'b0, "R11 free space cleared", tx_drq, 0);

    // R10 / R8 / R9 receive basics
    push_src(5, 1'b1);
    rx_rep(5);
    wait_src(0);
    check(rx_drq == 1'b0, "R10 rx_drq gated by enable", rx_drq, 0);
    rx_dma_en = 1'b1;
    repeat (3) @(negedge clk);
    check(rx_drq == 1'b1, "R10 rx_drq with buffered words", rx_drq, 1);
    for (int i = 0; i < 5; i++) rd_next("R8 read order");
    repeat (3) @(negedge clk);
    check(rx_drq == 1'b0, "R9 rx_drq falls after last read", rx_drq, 0);
    rd_check(16'h0, "R9 R8 empty read returns zero");

    // R7 block refill limited to DEPTH, R9 chained refill
    push_src(DEPTH + 6, 1'b1);
    rx_rep(DEPTH + 6);
    repeat (3) @(negedge clk);
    check(rx_ready == 1'b1, "R7 refill running", rx_ready, 1);
    rd_check(16'h0, "R8 read during refill returns zero");
    wait_src(6);
    check(rx_src.size() == 6 && rx_ready == 1'b0, "R7 refill stops at DEPTH",
          rx_src.size(), 6);
    for (int i = 0; i < DEPTH; i++) rd_next("R7 R8 first block data");
    wait_src(0);
    check(rx_src.size() == 0, "R9 second refill after last read", rx_src.size(), 0);
    for (int i = 0; i < 6; i++) rd_next("R9 second block data");
    repeat (3) @(negedge clk);
    check(rx_drq == 1'b0, "R9 rx_drq low when drained", rx_drq, 0);

    // R11 configuration change clears receive counts
    push_src(3, 1'b0);
    rx_rep(3);
    wait_src(0);
    check(rx_drq == 1'b1, "R10 rx_drq before config change", rx_drq, 1);
    cfg_pulse();
    repeat (3) @(negedge clk);
    check(rx_drq == 1'b0, "R11 rx_drq cleared", rx_drq, 0);
    rd_check(16'h0, "R11 receive buffer cleared");

    wait_idle();
    check(tx_exp.size() == 0, "R2 all expected tx samples seen", tx_exp.size(), 0);
    check(rx_exp.size() == 0, "R8 all expected rx samples read", rx_exp.size(), 0);
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule